// File: doc/BRIEF.md
# Audio Serial Transmitter (Right-Justified / I2S)

This block sends stereo PCM samples out on one serial data line. The bit clock and frame clock come from outside the block. Both are brought into the system clock domain through a synchroniser, and every falling edge of the bit clock is detected there. The serial output is then updated in the system clock cycle after that detection, so a receiver can sample it on the next rising edge of the bit clock.

Samples arrive as left-aligned 24-bit words through a valid/ready load. A loaded pair waits in a holding register. It moves to the active pair when the next left-channel period starts. If no pair is waiting at that point, the active pair is sent again.

The same serialiser supports two framings, chosen by an input:
- **Right-justified:** the word ends on the last bit before the frame clock changes. The block measures the channel length from the previous channel period so that it knows where the MSB falls.
- **I2S:** the word starts one bit clock after the frame change, and the channel polarity is the opposite of right-justified.

The word length is selectable.

Top module: `aud_tx`

## Requirements
- R1: `sdata_out` changes only in the system clock cycle that follows a detected falling edge of the synchronised bit clock. At all other times it holds its value.
- R2: In right-justified mode (`fmt_i2s`=0), the channel period is counted in bit-clock falling edges, starting at the edge where the frame clock level has changed. If the previous period was N edges long and the word is W bits, positions 0 to N-W-1 carry 0. Positions N-W to N-1 carry the word MSB first, so the LSB goes out on the last falling edge before the frame clock changes.
- R3: In right-justified mode, a high frame clock carries the left sample and a low frame clock carries the right sample.
- R4: In I2S mode (`fmt_i2s`=1), position 0 of a channel period carries 0. Positions 1 to W carry the word MSB first. Every later position up to the next frame change carries 0.
- R5: In I2S mode, a low frame clock carries the left sample and a high frame clock carries the right sample.
- R6: `wlen_sel` sets W as follows: 0 gives 16, 1 gives 20, 2 or 3 gives 24. Input bit 23 is the word MSB, and input bits below 24-W are never sent.
- R7: A waiting pair becomes the active pair at position 0 of a left-channel period, and that position already sends data from the new pair. If no pair is waiting, the previous active pair is sent again.
- R8: `load_ready` is high exactly when the holding register is empty. A load with `load_valid` and `load_ready` both high captures `left_in` and `right_in`, and `load_ready` goes low in the next cycle. While `load_ready` is low, `load_valid` is ignored, and `load_ready` stays low until a left-channel period starts.
- R9: Right after reset, `sdata_out` is 0 and `load_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_in | input | 1 | External bit clock (asynchronous) |
| lrck_in | input | 1 | External frame clock (asynchronous) |
| fmt_i2s | input | 1 | Framing select: 0 right-justified, 1 I2S |
| wlen_sel | input | 2 | Word length select |
| load_valid | input | 1 | Sample pair offered |
| load_ready | output | 1 | Holding register empty |
| left_in | input | 24 | Left sample, left-aligned |
| right_in | input | 24 | Right sample, left-aligned |
| sdata_out | output | 1 | Serial data output |

## Verification
The assertions assume that the framing and word-length inputs change only while the block is held in reset. They also assume that both external clocks run well below half the system clock rate, so that every bit-clock edge is seen. The stimulus satisfies both conditions:
- It changes the configuration only during reset.
- It holds each bit-clock phase for at least five system cycles.
- It changes the frame clock together with a falling bit-clock edge.
- It keeps I2S channel periods at least one bit longer than the word, and right-justified periods at least as long as the word.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;

   typedef enum logic {
      FMT_RJ  = 1'b0,
      FMT_I2S = 1'b1
   } aud_fmt_e;

   // Word length in bits for a select code, given the input sample width.
   function automatic int word_bits(input logic [1:0] sel, input int sw);
      case (sel)
         2'd0:    return sw - 8;
         2'd1:    return sw - 4;
         default: return sw;
      endcase
   endfunction

endpackage

// File: rtl/aud_tx_sync.sv
module aud_tx_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk_in,
   input  logic lrck_in,
   output logic bclk_fall,
   output logic lrck_lvl
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("aud_tx_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] b_sr;
   logic [STAGES-1:0] l_sr;
   logic              b_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         b_sr   <= '0;
         l_sr   <= '0;
         b_last <= 1'b0;
      end else begin
         b_sr   <= {b_sr[STAGES-2:0], bclk_in};
         l_sr   <= {l_sr[STAGES-2:0], lrck_in};
         b_last <= b_sr[STAGES-1];
      end
   end

   assign bclk_fall = b_last & ~b_sr[STAGES-1];
   assign lrck_lvl  = l_sr[STAGES-1];

endmodule

// File: rtl/aud_tx_hold.sv
module aud_tx_hold #(
   parameter int SW = 24
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_valid,
   input  logic [SW-1:0] left_in,
   input  logic [SW-1:0] right_in,
   input  logic          take,
   output logic          ready,
   output logic [SW-1:0] cur_l,
   output logic [SW-1:0] cur_r
);
   logic          full_q;
   logic [SW-1:0] hold_l, hold_r, act_l, act_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         full_q <= 1'b0;
         hold_l <= '0;
         hold_r <= '0;
         act_l  <= '0;
         act_r  <= '0;
      end else begin
         if (take && full_q) begin
            act_l <= hold_l;
            act_r <= hold_r;
         end
         if (load_valid && !full_q) begin
            hold_l <= left_in;
            hold_r <= right_in;
         end
         full_q <= (full_q & ~take) | (load_valid & ~full_q);
      end
   end

   assign ready = ~full_q;
   // Bypass so the first bit of a fresh left period already uses the new pair.
   assign cur_l = (take && full_q) ? hold_l : act_l;
   assign cur_r = (take && full_q) ? hold_r : act_r;

endmodule

// File: rtl/aud_tx_serial.sv
module aud_tx_serial
   import aud_tx_pkg::*;
#(
   parameter int SW    = 24,
   parameter int CNT_W = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bclk_fall,
   input  logic          lrck_lvl,
   input  aud_fmt_e      fmt,
   input  logic [1:0]    wlen_sel,
   input  logic [SW-1:0] cur_l,
   input  logic [SW-1:0] cur_r,
   output logic          boundary,
   output logic          take,
   output logic          sdata
);
   localparam int IDX_W = $clog2(SW);

   generate
      if ((1 << CNT_W) <= SW + 1) begin : g_bad_cnt
         $error("aud_tx_serial: CNT_W too small for the word length");
      end
   endgenerate

   logic [CNT_W-1:0] pos_q, len_q, pos_now, len_now, pos_inc, wl;
   logic             lrck_ref, is_left, bit_now;
   logic [SW-1:0]    sample;

   assign boundary = bclk_fall && (lrck_lvl != lrck_ref);
   assign is_left  = lrck_lvl ^ fmt;
   assign take     = boundary && is_left;

   assign pos_inc = (pos_q == '1) ? pos_q : pos_q + 1'b1;
   assign pos_now = boundary ? '0 : pos_inc;
   assign len_now = boundary ? pos_inc : len_q;
   assign wl      = CNT_W'(word_bits(wlen_sel, SW));
   assign sample  = is_left ? cur_l : cur_r;

   always_comb begin
      int idx;
      bit_now = 1'b0;
      idx     = 0;
      if (fmt == FMT_I2S) begin
         if (pos_now != '0 && pos_now <= wl) begin
            idx     = SW - int'(pos_now);
            bit_now = sample[idx[IDX_W-1:0]];
         end
      end else begin
         if (len_now >= wl && pos_now >= len_now - wl && pos_now < len_now) begin
            idx     = SW - int'(wl) + int'(len_now) - 1 - int'(pos_now);
            bit_now = sample[idx[IDX_W-1:0]];
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pos_q    <= '0;
         len_q    <= '0;
         lrck_ref <= 1'b0;
         sdata    <= 1'b0;
      end else if (bclk_fall) begin
         pos_q    <= pos_now;
         len_q    <= len_now;
         lrck_ref <= lrck_lvl;
         sdata    <= bit_now;
      end
   end

endmodule

// File: rtl/aud_tx.sv
module aud_tx
   import aud_tx_pkg::*;
#(
   parameter int SW          = 24,
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bclk_in,
   input  logic          lrck_in,
   input  logic          fmt_i2s,
   input  logic [1:0]    wlen_sel,
   input  logic          load_valid,
   output logic          load_ready,
   input  logic [SW-1:0] left_in,
   input  logic [SW-1:0] right_in,
   output logic          sdata_out
);
   generate
      if (SW < 9) begin : g_bad_sw
         $error("aud_tx: SW must exceed 8 bits");
      end
   endgenerate

   logic          bclk_fall, lrck_lvl, take, boundary;
   logic [SW-1:0] cur_l, cur_r;
   aud_fmt_e      fmt;

   assign fmt = aud_fmt_e'(fmt_i2s);

   aud_tx_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_in   (bclk_in),
      .lrck_in   (lrck_in),
      .bclk_fall (bclk_fall),
      .lrck_lvl  (lrck_lvl)
   );

   aud_tx_hold #(.SW(SW)) u_hold (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_valid (load_valid),
      .left_in    (left_in),
      .right_in   (right_in),
      .take       (take),
      .ready      (load_ready),
      .cur_l      (cur_l),
      .cur_r      (cur_r)
   );

   aud_tx_serial #(.SW(SW), .CNT_W(CNT_W)) u_ser (
      .clk       (clk),
      .rst_n     (rst_n),
      .bclk_fall (bclk_fall),
      .lrck_lvl  (lrck_lvl),
      .fmt       (fmt),
      .wlen_sel  (wlen_sel),
      .cur_l     (cur_l),
      .cur_r     (cur_r),
      .boundary  (boundary),
      .take      (take),
      .sdata     (sdata_out)
   );

endmodule

// File: rtl/aud_tx_chk.sv
module aud_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic fmt_i2s,
   input logic load_valid,
   input logic load_ready,
   input logic sdata_out,
   input logic bclk_fall,
   input logic boundary,
   input logic take
);
   AST_OUT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(bclk_fall) |-> $stable(sdata_out)); // R1

   AST_I2S_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (boundary && fmt_i2s) |=> !sdata_out); // R4

   AST_LOAD_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
      (load_valid && load_ready) |=> !load_ready); // R8

   AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_ready && !take) |=> !load_ready); // R8

   AST_FREE_AT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(load_ready) |-> $past(take)); // R7

endmodule

bind aud_tx aud_tx_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .fmt_i2s    (fmt_i2s),
   .load_valid (load_valid),
   .load_ready (load_ready),
   .sdata_out  (sdata_out),
   .bclk_fall  (bclk_fall),
   .boundary   (boundary),
   .take       (take)
);

// File: tb/aud_tx_tb.sv
module aud_tx_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bclk = 1'b1;
   logic        lrck = 1'b0;
   logic        fmt = 1'b0;
   logic [1:0]  wsel = 2'd0;
   logic        load_valid = 1'b0;
   logic        load_ready;
   logic [23:0] left_in = '0;
   logic [23:0] right_in = '0;
   logic        sdata_out;

   int total = 0;
   int bad = 0;
   int wbits = 16;

   always #4 clk = ~clk;

   aud_tx dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .bclk_in    (bclk),
      .lrck_in    (lrck),
      .fmt_i2s    (fmt),
      .wlen_sel   (wsel),
      .load_valid (load_valid),
      .load_ready (load_ready),
      .left_in    (left_in),
      .right_in   (right_in),
      .sdata_out  (sdata_out)
   );

   task automatic check(input string tag, input logic act, input logic exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
      end
   endtask

   function automatic logic exp_bit(input logic [23:0] s, input int p, input int n);
      if (fmt == 1'b0) begin
         if (p >= n - wbits) return s[24 - wbits + (n - 1 - p)];
         return 1'b0;
      end
      if (p >= 1 && p <= wbits) return s[24 - p];
      return 1'b0;
   endfunction

   function automatic logic [23:0] pat(input int c, input int k);
      return 24'((k + 1) * 32'h0006B2D9 + c * 32'h00013579 + 32'h00800000 * (k % 2));
   endfunction

   // One bit period: falling edge with the frame level, check before the rising edge.
   task automatic bit_step(input logic lvl, input logic [23:0] s, input int p,
                           input int n, input bit en, input string tag);
      logic mid;
      @(negedge clk);
      bclk = 1'b0;
      lrck = lvl;
      repeat (4) @(negedge clk);
      mid = sdata_out;
      repeat (2) @(negedge clk);
      if (en) begin
         check($sformatf("%s pos=%0d", tag, p), sdata_out, exp_bit(s, p, n));
         check("R1 held in low phase", sdata_out, mid);
      end
      bclk = 1'b1;
      repeat (5) @(negedge clk);
      if (en) check("R1 held in high phase", sdata_out, mid);
   endtask

   task automatic do_load(input logic [23:0] l, input logic [23:0] r);
      @(negedge clk);
      check("R8 ready before load", load_ready, 1'b1);
      load_valid = 1'b1;
      left_in    = l;
      right_in   = r;
      @(negedge clk);
      load_valid = 1'b0;
      check("R8 ready low after load", load_ready, 1'b0);
   endtask

   task automatic try_bad_load(input logic [23:0] l, input logic [23:0] r);
      @(negedge clk);
      load_valid = 1'b1;
      left_in    = l;
      right_in   = r;
      @(negedge clk);
      load_valid = 1'b0;
      check("R8 ready stays low", load_ready, 1'b0);
   endtask

   // mode: 0 no load, 1 load plus a refused attempt, 2 load only
   task automatic run_frame(input logic [23:0] l, input logic [23:0] r, input int n,
                            input bit en, input bit rep, input int mode,
                            input logic [23:0] nl, input logic [23:0] nr);
      logic  lv;
      string tl, tr;
      lv = ~fmt;
      tl = fmt ? "R5 R4 R6" : "R3 R2 R6";
      tr = fmt ? "R5 R4 R6 right" : "R3 R2 R6 right";
      if (rep) begin
         tl = {tl, " R7 repeat"};
         tr = {tr, " R7 repeat"};
      end
      for (int p = 0; p < n; p++) begin
         bit_step(lv, l, p, n, en, tl);
         if (p == 0 && en) check("R8 R7 ready after left start", load_ready, 1'b1);
      end
      for (int p = 0; p < n; p++) begin
         bit_step(~lv, r, p, n, en, tr);
         if (p == 1 && mode != 0) begin
            do_load(nl, nr);
            if (mode == 1) try_bad_load(~nl, ~nr);
         end
      end
   endtask

   initial begin
      int c;
      int n;
      c = 0;
      for (int fm = 0; fm < 2; fm++) begin
         for (int ws = 0; ws < 4; ws++) begin
            for (int nv = 0; nv < 2; nv++) begin
               logic [23:0] p0l, p0r, p1l, p1r, p2l, p2r;
               wbits = (ws == 0) ? 16 : (ws == 1) ? 20 : 24;
               n     = (nv == 1) ? 32 : (fm == 1 ? wbits + 1 : wbits);
               p0l = pat(c, 0); p0r = pat(c, 1);
               p1l = pat(c, 2); p1r = pat(c, 3);
               p2l = pat(c, 4); p2r = pat(c, 5);
               rst_n      = 1'b0;
               fmt        = fm[0];
               wsel       = ws[1:0];
               bclk       = 1'b1;
               lrck       = fm[0];
               load_valid = 1'b0;
               repeat (5) @(negedge clk);
               rst_n = 1'b1;
               @(negedge clk);
               check("R9 sdata after reset", sdata_out, 1'b0);
               check("R9 ready after reset", load_ready, 1'b1);
               do_load(p0l, p0r);
               for (int p = 0; p < 4; p++) bit_step(fm[0], '0, p, n, 1'b0, "pre");
               run_frame(p0l, p0r, n, 1'b0, 1'b0, 1, p1l, p1r);
               run_frame(p1l, p1r, n, 1'b1, 1'b0, 0, '0, '0);
               run_frame(p1l, p1r, n, 1'b1, 1'b1, 2, p2l, p2r);
               run_frame(p2l, p2r, n, 1'b1, 1'b0, 0, '0, '0);
               c++;
            end
         end
      end
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (195000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule